// File: doc/BRIEF.md
# Serial Interface Status Flags with Clock-Edge Counter

This block is the status register of a universal serial interface. It keeps a small counter of serial clock edges, a start flag, a counter-overflow flag, a stop flag and a read-only collision bit. The flags are set by bus events or by counter activity. Software clears a flag by writing a one to its bit. Each flag drives an interrupt request through its own enable and a global enable.

The counter advances on a one-cycle edge strobe from the shift logic, and a host write loads it directly. The start flag follows the wire mode. In two-wire modes a start condition on the bus lines sets it. In the other modes every counter increment sets it. While a start or overflow flag is pending in a two-wire mode, the block asks for the clock line to be held low. Clearing the flag releases that hold.

The bus lines are sampled once per cycle. A start is the data line falling while the clock line stays high. A stop is the data line rising while the clock line stays high.

Top module: `ser_status_flags`

## Requirements
- R1: After reset, status_o reads all zeros and start_irq_o, ovf_irq_o and scl_hold_o are low.
- R2: Field layout of status_o and wr_data_i: bits CNT_W-1..0 are the counter. A one-cycle edge_i increments the counter, modulo 2^CNT_W. A write (wr_en_i) loads the counter from wr_data_i[CNT_W-1:0]. An edge_i in the same cycle as a write is dropped.
- R3: The overflow flag (bit CNT_W+2, bit 6 by default) sets when an increment takes the counter from all ones to zero. Loading all ones by a write does not set it.
- R4: The start flag is bit CNT_W+3 (bit 7 by default). When wire_mode_i is 2 or 3 (two-wire), it sets when sda_i falls while scl_i is high in both the previous and current cycle. In these modes counter increments do not set it, and data changes while scl_i is low do not set it.
- R5: When wire_mode_i is 0 (output off) or 1 (three-wire), the start flag sets on every counter increment.
- R6: The stop flag (bit CNT_W+1, bit 5 by default) sets when sda_i rises while scl_i is high in both the previous and current cycle. This applies in every mode.
- R7: Writing a one to a flag bit clears that flag. Writing a zero leaves it unchanged. If the flag's set event falls in the same cycle as the clearing write, the flag stays set.
- R8: Bit CNT_W (bit 4 by default) always shows collision_i. Writes to that bit have no effect.
- R9: start_irq_o is high exactly when the start flag, start_ie_i and glb_ie_i are all set. ovf_irq_o is high exactly when the overflow flag, ovf_ie_i and glb_ie_i are all set.
- R10: scl_hold_o is high in the two-wire modes while the start or the overflow flag is set. In modes 0 and 1 it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wire_mode_i | input | 2 | 0 off, 1 three-wire, 2 and 3 two-wire |
| edge_i | input | 1 | Serial clock edge strobe, one cycle |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| collision_i | input | 1 | Data collision indication |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | CNT_W+4 | Host write data |
| start_ie_i | input | 1 | Start flag interrupt enable |
| ovf_ie_i | input | 1 | Overflow flag interrupt enable |
| glb_ie_i | input | 1 | Global interrupt enable |
| status_o | output | CNT_W+4 | Status register read value |
| start_irq_o | output | 1 | Start interrupt request |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| scl_hold_o | output | 1 | Hold clock line low |

## Verification
The bench builds the block with the default CNT_W of 4. At that width a full counter wrap takes only sixteen strobes, so the bench can reach the 15-to-0 transition both by counting and by loading 15 and stepping once. It also makes the 8-bit layout concrete, so flag clears and the ignored read-only bit can be checked at fixed positions. The bench drives the line sequences that should and should not count as start or stop in each wire-mode family. It also places a clearing write in the same cycle as a stop event.

// File: rtl/ser_status_pkg.sv
package ser_status_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_3W      = 2'd1,
    MODE_2W      = 2'd2,
    MODE_2W_HOLD = 2'd3
  } wire_mode_e;

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLG_STOP  = 0;
  localparam int unsigned FLG_OVF   = 1;
  localparam int unsigned FLG_START = 2;

  function automatic logic is_two_wire(input logic [1:0] mode);
    return mode[1];
  endfunction
endpackage

// File: rtl/ser_line_evt.sv
module ser_line_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  // idle bus is high on both lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
endmodule

// File: rtl/ser_edge_counter.sv
module ser_edge_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             inc_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign inc_o  = inc_i & ~ld_i;
  assign wrap_o = inc_o & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (inc_i) cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ser_flag.sv
module ser_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  // set beats clear so an event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= set_i | (q & ~clr_i);
  end

  assign q_o = q;
endmodule

// File: rtl/ser_status_flags.sv
module ser_status_flags
  import ser_status_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  localparam int unsigned REG_W = CNT_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       wire_mode_i,
  input  logic             edge_i,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             collision_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             start_ie_i,
  input  logic             ovf_ie_i,
  input  logic             glb_ie_i,
  output logic [REG_W-1:0] status_o,
  output logic             start_irq_o,
  output logic             ovf_irq_o,
  output logic             scl_hold_o
);
  localparam int unsigned FLG_LSB = CNT_W + 1;

  logic                 start_evt, stop_evt;
  logic [CNT_W-1:0]     cnt;
  logic                 cnt_inc, cnt_wrap;
  logic                 two_wire;
  logic [NUM_FLAGS-1:0] flg_set, flg_clr, flg_q;
  logic                 unused_ro_bit;

  assign two_wire      = is_two_wire(wire_mode_i);
  assign unused_ro_bit = wr_data_i[CNT_W];

  ser_line_evt u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (start_evt),
    .stop_o  (stop_evt)
  );

  ser_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (edge_i),
    .ld_i     (wr_en_i),
    .ld_val_i (wr_data_i[CNT_W-1:0]),
    .cnt_o    (cnt),
    .inc_o    (cnt_inc),
    .wrap_o   (cnt_wrap)
  );

  always_comb begin
    flg_set            = '0;
    flg_set[FLG_STOP]  = stop_evt;
    flg_set[FLG_OVF]   = cnt_wrap;
    flg_set[FLG_START] = two_wire ? start_evt : cnt_inc;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    assign flg_clr[g] = wr_en_i & wr_data_i[FLG_LSB+g];
    ser_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flg_set[g]),
      .clr_i  (flg_clr[g]),
      .q_o    (flg_q[g])
    );
  end

  assign status_o    = {flg_q, collision_i, cnt};
  assign start_irq_o = flg_q[FLG_START] & start_ie_i & glb_ie_i;
  assign ovf_irq_o   = flg_q[FLG_OVF] & ovf_ie_i & glb_ie_i;
  assign scl_hold_o  = two_wire & (flg_q[FLG_START] | flg_q[FLG_OVF]);
endmodule

// File: rtl/ser_status_chk.sv
module ser_status_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       wire_mode_i,
  input logic             edge_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_cnt_i,
  input logic             wr_ovf_i,
  input logic             glb_ie_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             ovf_i,
  input logic             start_i,
  input logic             start_irq_i,
  input logic             ovf_irq_i,
  input logic             hold_i
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !wr_en_i) |=> cnt_i == $past(cnt_i) + ONE); // R2
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cnt_i == $past(wr_cnt_i)); // R2
  AST_OVF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && !wr_en_i && (&cnt_i)) |=> ovf_i); // R3
  AST_START_ON_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wire_mode_i[1] && edge_i && !wr_en_i) |=> start_i); // R5
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !(wr_en_i && wr_ovf_i)) |=> ovf_i); // R7
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_ie_i |-> (!start_irq_i && !ovf_irq_i)); // R9
  AST_NO_HOLD_3W: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wire_mode_i[1] |-> !hold_i); // R10
endmodule

bind ser_status_flags ser_status_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wire_mode_i (wire_mode_i),
  .edge_i      (edge_i),
  .wr_en_i     (wr_en_i),
  .wr_cnt_i    (wr_data_i[CNT_W-1:0]),
  .wr_ovf_i    (wr_data_i[CNT_W+2]),
  .glb_ie_i    (glb_ie_i),
  .cnt_i       (status_o[CNT_W-1:0]),
  .ovf_i       (status_o[CNT_W+2]),
  .start_i     (status_o[CNT_W+3]),
  .start_irq_i (start_irq_o),
  .ovf_irq_i   (ovf_irq_o),
  .hold_i      (scl_hold_o)
);

// File: tb/ser_status_flags_tb.sv
module ser_status_flags_tb;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned REG_W = CNT_W + 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       wire_mode = 2'd1;
  logic             edge_s = 1'b0;
  logic             scl = 1'b1;
  logic             sda = 1'b1;
  logic             coll = 1'b0;
  logic             wr_en = 1'b0;
  logic [REG_W-1:0] wr_data = '0;
  logic             start_ie = 1'b0;
  logic             ovf_ie = 1'b0;
  logic             glb_ie = 1'b0;
  logic [REG_W-1:0] status;
  logic             start_irq, ovf_irq, hold;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ser_status_flags #(.CNT_W(CNT_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .wire_mode_i (wire_mode),
    .edge_i      (edge_s),
    .scl_i       (scl),
    .sda_i       (sda),
    .collision_i (coll),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .start_ie_i  (start_ie),
    .ovf_ie_i    (ovf_ie),
    .glb_ie_i    (glb_ie),
    .status_o    (status),
    .start_irq_o (start_irq),
    .ovf_irq_o   (ovf_irq),
    .scl_hold_o  (hold)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [REG_W-1:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic pulse_edge();
    edge_s = 1'b1;
    step();
    edge_s = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h00);
    chk("R1 irqs/hold", {start_irq, ovf_irq, hold}, 3'b000);
  endtask

  task automatic t_count_3w();
    wire_mode = 2'd1;
    wr(8'h00);
    repeat (3) pulse_edge();
    chk("R2/R5 count and start", status, 8'h83);
    wr_en = 1'b1; wr_data = 8'h0E; edge_s = 1'b1;
    step();
    wr_en = 1'b0; edge_s = 1'b0;
    chk("R2 write wins, R7 zero keeps flag", status, 8'h8E);
    pulse_edge();
    chk("R2 step to max", status, 8'h8F);
    pulse_edge();
    chk("R3 wrap sets overflow", status, 8'hC0);
    start_ie = 1'b1; ovf_ie = 1'b1; #1;
    chk("R9 no global", {start_irq, ovf_irq}, 2'b00);
    glb_ie = 1'b1; #1;
    chk("R9 both irqs", {start_irq, ovf_irq}, 2'b11);
    chk("R10 no hold in three-wire", hold, 1'b0);
    wr(8'hC0);
    chk("R7 clear by one", status, 8'h00);
    chk("R9 irqs drop", {start_irq, ovf_irq}, 2'b00);
    glb_ie = 1'b0;
    wr(8'h0F);
    chk("R3 load max no overflow", status, 8'h0F);
    pulse_edge();
    chk("R3 wrap after load", status, 8'hC0);
    wr(8'hC0);
  endtask

  task automatic t_mode_off();
    wire_mode = 2'd0;
    pulse_edge();
    chk("R5 output-off start on count", status, 8'h81);
    chk("R10 no hold in mode 0", hold, 1'b0);
    wr(8'h80);
    chk("R7 clear start", status, 8'h00);
  endtask

  task automatic t_two_wire();
    wire_mode = 2'd2;
    pulse_edge();
    chk("R4 count no start", status, 8'h01);
    sda = 1'b0;
    step();
    chk("R4 start condition", status, 8'h81);
    chk("R10 hold on start", hold, 1'b1);
    glb_ie = 1'b1; start_ie = 1'b1; #1;
    chk("R9 start irq only", {start_irq, ovf_irq}, 2'b10);
    glb_ie = 1'b0;
    wr(8'h81);
    chk("R7 clear start", status, 8'h01);
    chk("R10 hold released", hold, 1'b0);
    sda = 1'b1;
    step();
    chk("R6 stop condition", status, 8'h21);
    wr(8'h21);
    chk("R7 clear stop", status, 8'h01);
    scl = 1'b0; step();
    sda = 1'b0; step();
    sda = 1'b1; step();
    sda = 1'b0; step();
    scl = 1'b1; step();
    step();
    chk("R4/R6 no event while clock low", status, 8'h01);
    wr_en = 1'b1; wr_data = 8'h21; sda = 1'b1;
    step();
    wr_en = 1'b0;
    chk("R7 set wins over clear", status, 8'h21);
    wr(8'h21);
    wr(8'h0F);
    pulse_edge();
    chk("R3 overflow in two-wire", status, 8'h40);
    chk("R10 hold on overflow", hold, 1'b1);
    wire_mode = 2'd3; #1;
    chk("R10 hold in mode 3", hold, 1'b1);
    wr(8'h40);
    chk("R10 release on overflow clear", {hold, status}, {1'b0, 8'h00});
  endtask

  task automatic t_collision();
    coll = 1'b1; #1;
    chk("R8 collision shown", status, 8'h10);
    wr(8'h00);
    chk("R8 write ignored", status, 8'h10);
    coll = 1'b0; #1;
    chk("R8 follows input", status, 8'h00);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #2 rst_ni = 1'b1;
    step();
    t_reset();
    t_count_3w();
    t_mode_off();
    t_two_wire();
    t_collision();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule